// File: doc/BRIEF.md
# Shared-Timebase Capture/Compare Counter Array

This block is a peripheral timer with one 16-bit up-counter shared as the timebase for five capture/compare channels. The counter advances on a tick from one of four sources: the system clock divided by 12, the system clock divided by 4, a one-cycle overflow pulse from a neighbouring timer, or rising edges on an asynchronous external count pin. A run bit gates counting. An idle-stop bit can also freeze the counter while the chip signals idle.

Each channel has a 7-bit mode register, a 16-bit capture/compare register and one pin in each direction. The mode bits select the channel function:

- **FN_CAPTURE** latches the counter on chosen pin edges.
- **FN_TIMER** raises a flag when the counter reaches the register value.
- **FN_HSO** also toggles the output pin on that match.
- **FN_PWM** makes an 8-bit pulse-width output against the counter low byte. Its duty value is double-buffered and reloads when the low byte wraps.
- **FN_OFF** does nothing.

The function decode picks one of these values each cycle. The transitions between them are made only by mode-register writes:

- Any mode whose compare-enable bit is clear and either capture-edge bit is set goes to FN_CAPTURE.
- Compare-enable together with the PWM bit goes to FN_PWM.
- Compare-enable, match and toggle go to FN_HSO.
- Compare-enable and match without toggle go to FN_TIMER.
- Every other mode goes to FN_OFF.

A counter overflow flag and five channel flags are set by hardware and cleared only by software. They drive one interrupt line per channel and a combined interrupt line. A byte-wide register port stands in for processor access; reads are combinational.

Top module: `cc_array`

Register map (5-bit address, 8-bit data):

| Address | Contents |
|---|---|
| 0x00 | Control register |
| 0x01 | Flags register |
| 0x02 / 0x03 | Counter low / high byte |
| 0x08+n | Mode register of channel n |
| 0x10+2n / 0x11+2n | Capture/compare register of channel n, low / high byte |

## Requirements
- R1: After reset the counter, the control, mode and compare registers and all flags read 0, every `cex_out` bit is 1, and `irq_mod` and `irq_any` are 0.
- R2: Control bits [4:3] select the count source: 00 gives one tick every 12 clocks, 01 one every 4 clocks, 10 one per cycle of `tmr_ovf_in` high, 11 the external pin. Control bit 0 is run, bit 1 is idle-stop and bit 2 is the overflow interrupt enable.
- R3: With source 11 the counter advances exactly once per rising edge of `ext_cnt_in`, after a two-flop synchroniser.
- R4: The counter holds while run is 0, or while idle-stop and `idle_req` are both 1. With idle-stop at 0, `idle_req` has no effect.
- R5: A tick at counter value 0xFFFF wraps the counter to 0 and sets the overflow flag (flags bit 7). `irq_any` is high while that flag and control bit 2 are both set.
- R6: Writing the flags register clears each flag whose data bit is 0 and never sets a flag. A hardware set in the same cycle as a clearing write wins.
- R7: Mode bits are: bit0 compare enable, bit1 rising capture, bit2 falling capture, bit3 match flag, bit4 toggle, bit5 PWM, bit6 channel interrupt enable. With bit0 clear, a selected edge on the synchronised `cex_in[n]` copies the counter into the channel register and sets flag bit n. Edges that are not selected change nothing.
- R8: With bits 0 and 3 set, the counter advancing to a value equal to the channel register sets flag bit n. With bit 3 clear no flag is set.
- R9: With bits 0, 3 and 4 set, `cex_out[n]` toggles on each match.
- R10: With bits 0 and 5 set, `cex_out[n]` is 0 while the counter low byte is below the channel low byte, and 1 when it is equal or greater.
- R11: In PWM mode, a tick that takes the counter low byte from 0xFF to 0x00 loads the channel low byte from its high byte.
- R12: `irq_mod[n]` is flag n AND mode bit 6. `irq_any` also goes high for any asserted `irq_mod` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| idle_req | input | 1 | Chip idle indication |
| tmr_ovf_in | input | 1 | Overflow pulse from a neighbouring timer |
| ext_cnt_in | input | 1 | Asynchronous external count pin |
| cex_in | input | 5 | Channel input pins |
| cex_out | output | 5 | Channel output pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_mod | output | 5 | Per-channel interrupt requests |
| irq_any | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a hardware flag set landing in the same clock as a software write that clears that flag. The bench preloads the counter with 0xFFFF through the register port and selects the neighbour-overflow source. It then drives `tmr_ovf_in` and a clearing flags write together for one cycle, so the wrap and the clear meet at the same edge. The PWM reload at low-byte wrap is reached the same way. The counter is parked at 0x00FF and one tick is issued, which avoids 256 clocks of free running.

// File: rtl/cca_pkg.sv
package cca_pkg;
    localparam int CNT_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int A_CTRL     = 0;
    localparam int A_FLAGS    = 1;
    localparam int A_CNT_LO   = 2;
    localparam int A_CNT_HI   = 3;
    localparam int A_MODE_BASE = 8;
    localparam int A_CMP_BASE  = 16;

    typedef enum logic [1:0] {
        SRC_DIV_SLOW = 2'b00,
        SRC_DIV_FAST = 2'b01,
        SRC_NEIGHBOR = 2'b10,
        SRC_EXT_PIN  = 2'b11
    } cca_src_e;

    typedef enum logic [2:0] {
        FN_OFF,
        FN_CAPTURE,
        FN_TIMER,
        FN_HSO,
        FN_PWM
    } cca_fn_e;

    typedef struct packed {
        logic irq_en;
        logic pwm;
        logic tog;
        logic mat;
        logic capn;
        logic capp;
        logic ecom;
    } cca_mode_t;
endpackage

// File: rtl/cca_tick.sv
module cca_tick #(
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cca_pkg::cca_src_e src,
    input  logic              run,
    input  logic              idle_stop,
    input  logic              idle_req,
    input  logic              tmr_ovf,
    input  logic              ext_in,
    output logic              step
);
    import cca_pkg::*;

    localparam int SW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
    localparam int FW = (DIV_FAST > 1) ? $clog2(DIV_FAST) : 1;

    logic [SW-1:0]          pre_slow;
    logic [FW-1:0]          pre_fast;
    logic                   tick_slow, tick_fast;
    logic [SYNC_STAGES-1:0] ext_sync;
    logic                   ext_prev, ext_rise;
    logic                   raw_tick;

    assign tick_slow = (pre_slow == SW'(DIV_SLOW - 1));
    assign tick_fast = (pre_fast == FW'(DIV_FAST - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_slow <= '0;
            pre_fast <= '0;
        end else begin
            pre_slow <= tick_slow ? '0 : pre_slow + 1'b1;
            pre_fast <= tick_fast ? '0 : pre_fast + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_sync <= '0;
            ext_prev <= 1'b0;
        end else begin
            ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_in};
            ext_prev <= ext_sync[SYNC_STAGES-1];
        end
    end

    assign ext_rise = ext_sync[SYNC_STAGES-1] & ~ext_prev;

    always_comb begin
        unique case (src)
            SRC_DIV_SLOW: raw_tick = tick_slow;
            SRC_DIV_FAST: raw_tick = tick_fast;
            SRC_NEIGHBOR: raw_tick = tmr_ovf;
            SRC_EXT_PIN:  raw_tick = ext_rise;
            default:      raw_tick = 1'b0;
        endcase
    end

    assign step = raw_tick & run & ~(idle_stop & idle_req);

    // R2: the slow divider never ticks in two adjacent cycles
    p_slow_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_slow |=> !tick_slow);

    // R3: an external-pin tick needs a synchronised low-to-high change
    p_ext_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_EXT_PIN && step) |-> ($past(ext_sync[SYNC_STAGES-1]) == 1'b0));
endmodule

// File: rtl/cca_count.sv
module cca_count (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step,
    input  logic                      wr_lo,
    input  logic                      wr_hi,
    input  logic [cca_pkg::BYTE_W-1:0] wdata,
    output logic [cca_pkg::CNT_W-1:0]  cnt_q,
    output logic                      ovf,
    output logic                      lo_roll,
    output logic                      adv_q
);
    import cca_pkg::*;

    logic sw_wr, inc;

    assign sw_wr   = wr_lo | wr_hi;
    assign inc     = step & ~sw_wr;
    assign ovf     = inc & (cnt_q == {CNT_W{1'b1}});
    assign lo_roll = inc & (cnt_q[BYTE_W-1:0] == {BYTE_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            adv_q <= 1'b0;
        end else begin
            adv_q <= inc;
            if (sw_wr) begin
                if (wr_lo) cnt_q[BYTE_W-1:0]     <= wdata;
                if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wdata;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R5: a tick at the top value wraps the counter to zero
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == '0));

    // R4: with no tick and no write the counter holds
    p_hold_no_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !sw_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/cca_chan.sv
module cca_chan #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  cca_pkg::cca_mode_t         mode,
    input  logic [cca_pkg::CNT_W-1:0]  cnt,
    input  logic                       adv,
    input  logic                       lo_roll,
    input  logic                       wr_lo,
    input  logic                       wr_hi,
    input  logic [cca_pkg::BYTE_W-1:0] wdata,
    input  logic                       pin_in,
    output logic [cca_pkg::CNT_W-1:0]  cmp_val,
    output logic                       pin_out,
    output logic                       hit
);
    import cca_pkg::*;

    cca_fn_e                fn;
    logic [SYNC_STAGES-1:0] pin_sync;
    logic                   pin_prev, rise, fall;
    logic                   match, cap_hit, toggle, reload;
    logic [BYTE_W-1:0]      lo_q, hi_q;
    logic                   pin_q;

    assign cmp_val = {hi_q, lo_q};
    assign match   = adv & (cnt == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_sync <= '0;
            pin_prev <= 1'b0;
        end else begin
            pin_sync <= {pin_sync[SYNC_STAGES-2:0], pin_in};
            pin_prev <= pin_sync[SYNC_STAGES-1];
        end
    end

    assign rise = pin_sync[SYNC_STAGES-1] & ~pin_prev;
    assign fall = ~pin_sync[SYNC_STAGES-1] & pin_prev;

    // function decode: the mode register picks the channel function
    always_comb begin
        if (mode.ecom) begin
            if (mode.pwm)                 fn = FN_PWM;
            else if (mode.mat && mode.tog) fn = FN_HSO;
            else if (mode.mat)            fn = FN_TIMER;
            else                          fn = FN_OFF;
        end else if (mode.capp || mode.capn) begin
            fn = FN_CAPTURE;
        end else begin
            fn = FN_OFF;
        end
    end

    // per-function event generation
    always_comb begin
        cap_hit = 1'b0;
        hit     = 1'b0;
        toggle  = 1'b0;
        reload  = 1'b0;
        unique case (fn)
            FN_CAPTURE: begin
                cap_hit = (mode.capp & rise) | (mode.capn & fall);
                hit     = cap_hit;
            end
            FN_TIMER: hit = match;
            FN_HSO: begin
                hit    = match;
                toggle = match;
            end
            FN_PWM:  reload = lo_roll;
            FN_OFF:  ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            pin_q <= 1'b1;
        end else begin
            if (cap_hit) begin
                {hi_q, lo_q} <= cnt;
            end else begin
                if (reload)     lo_q <= hi_q;
                else if (wr_lo) lo_q <= wdata;
                if (wr_hi)      hi_q <= wdata;
            end
            if (toggle) pin_q <= ~pin_q;
        end
    end

    assign pin_out = (fn == FN_PWM) ? (cnt[BYTE_W-1:0] >= lo_q) : pin_q;

    // R7: a capture event stores the counter value of that cycle
    p_capture_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (cmp_val == $past(cnt)));

    // R9: a toggle event inverts the held pin level
    p_toggle_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (pin_q != $past(pin_q)));

    // R11: a low-byte wrap in PWM mode copies the high byte down
    p_pwm_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (lo_q == $past(hi_q)));
endmodule

// File: rtl/cc_array.sv
module cc_array #(
    parameter int NUM_MOD     = 5,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idle_req,
    input  logic               tmr_ovf_in,
    input  logic               ext_cnt_in,
    input  logic [NUM_MOD-1:0] cex_in,
    output logic [NUM_MOD-1:0] cex_out,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic [NUM_MOD-1:0] irq_mod,
    output logic               irq_any
);
    import cca_pkg::*;

    localparam int CTRL_W = 5;
    localparam int MODE_W = $bits(cca_mode_t);

    logic [CTRL_W-1:0]  ctrl_q;
    cca_mode_t          mode_q [NUM_MOD];
    logic               cf_q;
    logic [NUM_MOD-1:0] ccf_q;
    logic [NUM_MOD-1:0] hit_vec, ien_vec, keep_vec;
    logic [CNT_W-1:0]   cmp_all [NUM_MOD];
    logic [CNT_W-1:0]   cnt;
    logic               step, ovf, lo_roll, adv;
    logic               wr_ctrl, wr_flags, wr_cnt_lo, wr_cnt_hi;
    logic [NUM_MOD-1:0] wr_mode, wr_cmp_lo, wr_cmp_hi;

    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign wr_flags  = reg_wr && (reg_addr == ADDR_W'(A_FLAGS));
    assign wr_cnt_lo = reg_wr && (reg_addr == ADDR_W'(A_CNT_LO));
    assign wr_cnt_hi = reg_wr && (reg_addr == ADDR_W'(A_CNT_HI));

    cca_tick #(
        .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk(clk), .rst_n(rst_n),
        .src(cca_src_e'(ctrl_q[4:3])),
        .run(ctrl_q[0]), .idle_stop(ctrl_q[1]), .idle_req(idle_req),
        .tmr_ovf(tmr_ovf_in), .ext_in(ext_cnt_in), .step(step)
    );

    cca_count u_count (
        .clk(clk), .rst_n(rst_n), .step(step),
        .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wdata(reg_wdata),
        .cnt_q(cnt), .ovf(ovf), .lo_roll(lo_roll), .adv_q(adv)
    );

    for (genvar n = 0; n < NUM_MOD; n++) begin : g_chan
        assign wr_mode[n]   = reg_wr && (reg_addr == ADDR_W'(A_MODE_BASE + n));
        assign wr_cmp_lo[n] = reg_wr && (reg_addr == ADDR_W'(A_CMP_BASE + 2*n));
        assign wr_cmp_hi[n] = reg_wr && (reg_addr == ADDR_W'(A_CMP_BASE + 2*n + 1));
        assign ien_vec[n]   = mode_q[n].irq_en;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          mode_q[n] <= '0;
            else if (wr_mode[n]) mode_q[n] <= cca_mode_t'(reg_wdata[MODE_W-1:0]);
        end

        cca_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk(clk), .rst_n(rst_n), .mode(mode_q[n]),
            .cnt(cnt), .adv(adv), .lo_roll(lo_roll),
            .wr_lo(wr_cmp_lo[n]), .wr_hi(wr_cmp_hi[n]), .wdata(reg_wdata),
            .pin_in(cex_in[n]), .cmp_val(cmp_all[n]),
            .pin_out(cex_out[n]), .hit(hit_vec[n])
        );
    end

    assign keep_vec = wr_flags ? reg_wdata[NUM_MOD-1:0] : {NUM_MOD{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cf_q   <= 1'b0;
            ccf_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
            cf_q  <= ovf | (cf_q & ~(wr_flags & ~reg_wdata[7]));
            ccf_q <= hit_vec | (ccf_q & keep_vec);
        end
    end

    assign irq_mod = ccf_q & ien_vec;
    assign irq_any = (cf_q & ctrl_q[2]) | (|irq_mod);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL)) begin
            reg_rdata[CTRL_W-1:0] = ctrl_q;
        end else if (reg_addr == ADDR_W'(A_FLAGS)) begin
            reg_rdata[7]           = cf_q;
            reg_rdata[NUM_MOD-1:0] = ccf_q;
        end else if (reg_addr == ADDR_W'(A_CNT_LO)) begin
            reg_rdata = cnt[7:0];
        end else if (reg_addr == ADDR_W'(A_CNT_HI)) begin
            reg_rdata = cnt[15:8];
        end
        for (int n = 0; n < NUM_MOD; n++) begin
            if (reg_addr == ADDR_W'(A_MODE_BASE + n))
                reg_rdata[MODE_W-1:0] = mode_q[n];
            if (reg_addr == ADDR_W'(A_CMP_BASE + 2*n))
                reg_rdata = cmp_all[n][7:0];
            if (reg_addr == ADDR_W'(A_CMP_BASE + 2*n + 1))
                reg_rdata = cmp_all[n][15:8];
        end
    end

    // R6: the overflow flag survives anything but a clearing write
    p_cf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_q && !(wr_flags && !reg_wdata[7])) |=> cf_q);

    // R6: a channel event always leaves its flag set, even against a clear
    p_ccf_hw_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |=> ((ccf_q & $past(hit_vec)) == $past(hit_vec)));

    // R5: a wrap always sets the overflow flag
    p_ovf_sets_cf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> cf_q);
endmodule

// File: tb/tb_cc_array.sv
module tb_cc_array;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         idle_req = 1'b0;
    logic         tmr_ovf_in = 1'b0;
    logic         ext_cnt_in = 1'b0;
    logic [N-1:0] cex_in = '0;
    logic [N-1:0] cex_out;
    logic         reg_wr = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;
    logic [N-1:0] irq_mod;
    logic         irq_any;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cc_array dut (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req),
        .tmr_ovf_in(tmr_ovf_in), .ext_cnt_in(ext_cnt_in),
        .cex_in(cex_in), .cex_out(cex_out),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_mod(irq_mod), .irq_any(irq_any)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_now(a, d);
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(5'd2, v[7:0]);
        wr(5'd3, v[15:8]);
    endtask

    task automatic get_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(5'd2, lo);
        rd_now(5'd3, hi);
        v = {hi, lo};
    endtask

    task automatic pulse_t0();
        @(negedge clk);
        tmr_ovf_in = 1'b1;
        @(negedge clk);
        tmr_ovf_in = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic [15:0] c;
        rd(5'd0, d);  chk("R1", "ctrl", 16'(d), 16'h0);
        rd(5'd1, d);  chk("R1", "flags", 16'(d), 16'h0);
        get_cnt(c);   chk("R1", "counter", c, 16'h0);
        rd(5'd8, d);  chk("R1", "mode0", 16'(d), 16'h0);
        rd(5'd16, d); chk("R1", "cmp0 lo", 16'(d), 16'h0);
        chk("R1", "pins", 16'(cex_out), 16'h1F);
        chk("R1", "irq", {15'h0, irq_any} | 16'(irq_mod), 16'h0);
    endtask

    task automatic t_sources();
        logic [15:0] c;
        logic [7:0] d;
        // R2 slow divider: 120 clocks give 10 ticks
        set_cnt(16'h0);
        wr(5'd0, 8'h01);
        repeat (120) @(negedge clk);
        rd_now(5'd2, d);
        chk("R2", "div12 count", 16'(d), 16'd10);
        wr(5'd0, 8'h00);
        // R2 fast divider: 40 clocks give 10 ticks
        set_cnt(16'h0);
        wr(5'd0, 8'h09);
        repeat (40) @(negedge clk);
        rd_now(5'd2, d);
        chk("R2", "div4 count", 16'(d), 16'd10);
        wr(5'd0, 8'h00);
        // R2 neighbour overflow pulses
        set_cnt(16'h0);
        wr(5'd0, 8'h11);
        repeat (3) pulse_t0();
        get_cnt(c);
        chk("R2", "neighbour count", c, 16'd3);
        // R3 external rising edges
        set_cnt(16'h0);
        wr(5'd0, 8'h19);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ext_cnt_in = 1'b1;
            repeat (3) @(negedge clk);
            ext_cnt_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        get_cnt(c);
        chk("R3", "external edges", c, 16'd5);
        wr(5'd0, 8'h00);
    endtask

    task automatic t_gating();
        logic [15:0] c;
        set_cnt(16'h0100);
        wr(5'd0, 8'h10);
        pulse_t0();
        get_cnt(c);
        chk("R4", "run clear holds", c, 16'h0100);
        wr(5'd0, 8'h13);
        idle_req = 1'b1;
        pulse_t0();
        get_cnt(c);
        chk("R4", "idle stop holds", c, 16'h0100);
        idle_req = 1'b0;
        pulse_t0();
        get_cnt(c);
        chk("R4", "idle low counts", c, 16'h0101);
        wr(5'd0, 8'h11);
        idle_req = 1'b1;
        pulse_t0();
        get_cnt(c);
        chk("R4", "idle ignored", c, 16'h0102);
        idle_req = 1'b0;
    endtask

    task automatic t_overflow();
        logic [15:0] c;
        logic [7:0] d;
        wr(5'd0, 8'h10);
        set_cnt(16'hFFFF);
        wr(5'd0, 8'h15);
        pulse_t0();
        get_cnt(c);
        chk("R5", "wrap value", c, 16'h0000);
        rd(5'd1, d);
        chk("R5", "overflow flag", 16'(d[7]), 16'h1);
        chk("R5", "irq_any", 16'(irq_any), 16'h1);
        wr(5'd1, 8'h7F);
        rd(5'd1, d);
        chk("R6", "flag cleared by 0", 16'(d), 16'h0);
        chk("R6", "irq_any after clear", 16'(irq_any), 16'h0);
        wr(5'd1, 8'hFF);
        rd(5'd1, d);
        chk("R6", "write 1 does not set", 16'(d), 16'h0);
        // same-cycle clear against hardware set
        set_cnt(16'hFFFF);
        @(negedge clk);
        tmr_ovf_in = 1'b1; reg_wr = 1'b1; reg_addr = 5'd1; reg_wdata = 8'h00;
        @(negedge clk);
        tmr_ovf_in = 1'b0; reg_wr = 1'b0;
        rd(5'd1, d);
        chk("R6", "hardware set wins", 16'(d[7]), 16'h1);
        wr(5'd1, 8'h00);
        wr(5'd0, 8'h00);
    endtask

    task automatic t_capture();
        logic [7:0] lo, hi, f;
        set_cnt(16'h1234);
        wr(5'd8, 8'h02);
        @(negedge clk); cex_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd(5'd16, lo); rd_now(5'd17, hi);
        chk("R7", "rising capture", {hi, lo}, 16'h1234);
        rd(5'd1, f);
        chk("R7", "capture flag", 16'(f), 16'h01);
        wr(5'd1, 8'h00);
        wr(5'd8, 8'h04);
        set_cnt(16'h1111);
        @(negedge clk); cex_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(5'd16, lo); rd_now(5'd17, hi);
        chk("R7", "falling capture", {hi, lo}, 16'h1111);
        wr(5'd1, 8'h00);
        set_cnt(16'h2222);
        @(negedge clk); cex_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd(5'd16, lo); rd_now(5'd17, hi);
        chk("R7", "rising ignored value", {hi, lo}, 16'h1111);
        rd(5'd1, f);
        chk("R7", "rising ignored flag", 16'(f), 16'h00);
        wr(5'd8, 8'h06);
        set_cnt(16'h3333);
        @(negedge clk); cex_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(5'd16, lo); rd_now(5'd17, hi);
        chk("R7", "either-edge capture", {hi, lo}, 16'h3333);
        wr(5'd8, 8'h00);
        wr(5'd1, 8'h00);
    endtask

    task automatic t_timer();
        logic [7:0] f;
        wr(5'd9, 8'h09);
        wr(5'd18, 8'h05);
        wr(5'd19, 8'h00);
        set_cnt(16'h0003);
        wr(5'd0, 8'h11);
        pulse_t0();
        rd(5'd1, f);
        chk("R8", "no flag before match", 16'(f), 16'h00);
        pulse_t0();
        rd(5'd1, f);
        chk("R8", "match flag", 16'(f), 16'h02);
        chk("R12", "irq_mod masked", 16'(irq_mod), 16'h00);
        chk("R12", "irq_any masked", 16'(irq_any), 16'h0);
        wr(5'd9, 8'h49);
        @(negedge clk);
        chk("R12", "irq_mod enabled", 16'(irq_mod), 16'h02);
        chk("R12", "irq_any enabled", 16'(irq_any), 16'h1);
        wr(5'd1, 8'h00);
        wr(5'd9, 8'h01);
        set_cnt(16'h0004);
        pulse_t0();
        rd(5'd1, f);
        chk("R8", "no flag without match bit", 16'(f), 16'h00);
        wr(5'd9, 8'h00);
    endtask

    task automatic t_hso();
        logic [7:0] f;
        wr(5'd10, 8'h19);
        wr(5'd20, 8'h02);
        wr(5'd21, 8'h00);
        set_cnt(16'h0001);
        pulse_t0();
        @(negedge clk);
        chk("R9", "pin after first match", 16'(cex_out[2]), 16'h0);
        rd(5'd1, f);
        chk("R9", "hso flag", 16'(f), 16'h04);
        set_cnt(16'h0001);
        pulse_t0();
        @(negedge clk);
        chk("R9", "pin after second match", 16'(cex_out[2]), 16'h1);
        wr(5'd10, 8'h00);
        wr(5'd1, 8'h00);
    endtask

    task automatic t_pwm();
        logic [7:0] d;
        wr(5'd11, 8'h21);
        wr(5'd22, 8'h40);
        wr(5'd23, 8'h80);
        set_cnt(16'h0030);
        @(negedge clk);
        chk("R10", "below duty", 16'(cex_out[3]), 16'h0);
        set_cnt(16'h0040);
        @(negedge clk);
        chk("R10", "equal duty", 16'(cex_out[3]), 16'h1);
        set_cnt(16'h00FF);
        pulse_t0();
        rd(5'd22, d);
        chk("R11", "reloaded low byte", 16'(d), 16'h80);
        chk("R11", "output after reload", 16'(cex_out[3]), 16'h0);
        set_cnt(16'h0090);
        @(negedge clk);
        chk("R10", "above new duty", 16'(cex_out[3]), 16'h1);
        chk("R10", "idle channel pin", 16'(cex_out[4]), 16'h1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sources();
        t_gating();
        t_overflow();
        t_capture();
        t_timer();
        t_hso();
        t_pwm();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule